// File: doc/BRIEF.md
# Phase-Offset Cosine Oscillator

This block is one numerically controlled oscillator channel. A 32-bit phase accumulator advances by a frequency tuning word on every clock. The output frequency is therefore the tuning word times the clock rate divided by 2^32. The fourteen most significant accumulator bits form a coarse phase. A 14-bit phase offset is added to that phase, modulo 2^14, so one offset step is 360°/16384. The offset acts only on the value fed to the amplitude stage and never changes the running accumulator. The summed phase addresses a quarter-wave cosine table that is computed at elaboration. The quadrant logic turns the table output into a signed 10-bit amplitude.

The tuning word and the offset word are presented together with a one-cycle update strobe. Both are captured at the same edge and used from the following edge on. A tuning word of zero stops the accumulator, so the output holds a constant level. The output is a free-running sample stream with a valid flag and no ready input. The block cannot be stalled: one sample is produced on every clock after reset, and a consumer that cannot keep pace must decimate or buffer on its own side.

Top module: `dds_cos_gen`

## Requirements
- R1: While reset is high, at every clock edge, the accumulator, the active tuning word and the active offset word clear to zero, and `valid_o` and `amp_o` clear to 0.
- R2: `valid_o` goes high at the first clock edge after reset is released and stays high until the next reset. There is no back-pressure: a new sample is produced on every edge.
- R3: At each edge the accumulator adds the active tuning word, modulo 2^32. The coarse phase is accumulator bits [31:18].
- R4: A tuning word greater than 2^31 is captured as exactly 2^31. For example, 0xFFFFFFFF makes successive samples exact negatives of each other.
- R5: The amplitude phase is (coarse phase + active offset) mod 2^14. Changing the offset never alters the accumulator, so removing an offset restores the unshifted waveform at once.
- R6: When `upd_i` is high at an edge, `ftw_i` and `pow_i` are captured together and take effect from the next edge. When `upd_i` is low, changes on `ftw_i` and `pow_i` have no effect.
- R7: `amp_o` is a two's-complement 10-bit code. After edge n it is within 1 LSB of 511·cos(2π·p/16384), where p is the amplitude phase as it stood just before edge n. Phase 0 gives +511.
- R8: With an active tuning word of zero, `amp_o` is identical on every edge from the second edge after the zero word took effect, as long as no new update arrives.
- R9: `amp_o` stays within ±511 and never takes the code -512.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_i | input | 1 | Synchronous reset, active high |
| upd_i | input | 1 | Update strobe for tuning and offset words |
| ftw_i | input | 32 | Frequency tuning word |
| pow_i | input | 14 | Phase offset word, 360°/16384 per step |
| amp_o | output | 10 | Signed cosine amplitude |
| valid_o | output | 1 | Sample valid, high on every cycle after reset |

## Verification
A wrong accumulator value or a wrong captured word appears at `amp_o` on the very next edge, because the path from accumulator to output holds only one register. A full sweep of the 16384 phase codes at one code per cycle exposes a table entry, a quadrant sign or a mirrored index that is wrong within that single sweep. A phase slip in the accumulator drifts away from the arithmetic model and is caught on the cycle where it starts. A mistake in the clamp or in the capture of the offset shows up within a cycle or two of the update that triggers it.

// File: rtl/dds_pkg.sv
package dds_pkg;
  // quadrant of the full cosine period, decoded from the two phase MSBs
  typedef enum logic [1:0] {
    QUAD_0 = 2'd0,
    QUAD_1 = 2'd1,
    QUAD_2 = 2'd2,
    QUAD_3 = 2'd3
  } quad_e;
endpackage

// File: rtl/dds_word_latch.sv
module dds_word_latch #(
  parameter int ACC_W   = 32,
  parameter int PHASE_W = 14
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               upd_i,
  input  logic [ACC_W-1:0]   ftw_i,
  input  logic [PHASE_W-1:0] pow_i,
  output logic [ACC_W-1:0]   ftw_o,
  output logic [PHASE_W-1:0] pow_o
);
  localparam logic [ACC_W-1:0] FTW_MAX = {1'b1, {(ACC_W-1){1'b0}}};

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ftw_o <= '0;
      pow_o <= '0;
    end else if (upd_i) begin
      ftw_o <= (ftw_i > FTW_MAX) ? FTW_MAX : ftw_i;
      pow_o <= pow_i;
    end
  end
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W   = 32,
  parameter int PHASE_W = 14
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [ACC_W-1:0]   ftw_i,
  input  logic [PHASE_W-1:0] pow_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) acc_q <= '0;
    else       acc_q <= acc_q + ftw_i;
  end

  // offset is applied on the way out only; the running phase is untouched
  assign phase_o = acc_q[ACC_W-1 -: PHASE_W] + pow_i;
endmodule

// File: rtl/dds_cos_lut.sv
module dds_cos_lut
  import dds_pkg::*;
#(
  parameter int PHASE_W = 14,
  parameter int AMP_W   = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic [PHASE_W-1:0]      phase_i,
  output logic signed [AMP_W-1:0] amp_o,
  output logic                    valid_o
);
  localparam int  QW    = PHASE_W - 2;
  localparam int  QSIZE = 1 << QW;
  localparam int  FULL  = (1 << (AMP_W - 1)) - 1;
  localparam real PI    = 3.14159265358979323846;

  logic [AMP_W-2:0] qtab [QSIZE];

  // half-step sample points make the quarter symmetric, so mirroring is a bit inversion
  for (genvar gi = 0; gi < QSIZE; gi++) begin : g_tab
    localparam real ANG = (real'(gi) + 0.5) * PI / (2.0 * real'(QSIZE));
    localparam int  VAL = int'($floor(real'(FULL) * $cos(ANG) + 0.5));
    assign qtab[gi] = VAL[AMP_W-2:0];
  end

  quad_e                   quad;
  logic [QW-1:0]           low;
  logic [QW-1:0]           idx;
  logic                    neg;
  logic signed [AMP_W-1:0] mag_s;
  logic signed [AMP_W-1:0] amp_d;

  always_comb begin
    quad  = quad_e'(phase_i[PHASE_W-1 -: 2]);
    low   = phase_i[QW-1:0];
    idx   = (quad == QUAD_1 || quad == QUAD_3) ? ~low : low;
    neg   = (quad == QUAD_1 || quad == QUAD_2);
    mag_s = {1'b0, qtab[idx]};
    amp_d = neg ? -mag_s : mag_s;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      amp_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      amp_o   <= amp_d;
      valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dds_cos_gen.sv
module dds_cos_gen #(
  parameter int ACC_W   = 32,
  parameter int PHASE_W = 14,
  parameter int AMP_W   = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    upd_i,
  input  logic [ACC_W-1:0]        ftw_i,
  input  logic [PHASE_W-1:0]      pow_i,
  output logic signed [AMP_W-1:0] amp_o,
  output logic                    valid_o
);
  logic [ACC_W-1:0]   ftw_act;
  logic [PHASE_W-1:0] pow_act;
  logic [PHASE_W-1:0] phase;

  dds_word_latch #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) latch_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .upd_i (upd_i),
    .ftw_i (ftw_i),
    .pow_i (pow_i),
    .ftw_o (ftw_act),
    .pow_o (pow_act)
  );

  dds_phase_acc #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) acc_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .ftw_i   (ftw_act),
    .pow_i   (pow_act),
    .phase_o (phase)
  );

  dds_cos_lut #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) lut_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .phase_i (phase),
    .amp_o   (amp_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/dds_cos_gen_chk.sv
module dds_cos_gen_chk #(
  parameter int ACC_W = 32,
  parameter int AMP_W = 10
) (
  input logic                    clk_i,
  input logic                    rst_i,
  input logic                    upd_i,
  input logic [ACC_W-1:0]        ftw_i,
  input logic signed [AMP_W-1:0] amp_o,
  input logic                    valid_o
);
  localparam logic [AMP_W-1:0] MIN_CODE = {1'b1, {(AMP_W-1){1'b0}}};

  // tracks from the ports whether a zero tuning word is active
  logic frz_q;
  logic frz2_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      frz_q  <= 1'b1;
      frz2_q <= 1'b0;
    end else begin
      if (upd_i) frz_q <= (ftw_i == '0);
      frz2_q <= frz_q && !upd_i;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    rst_i |=> (!valid_o && amp_o == '0));

  assert_valid_stream_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> valid_o);

  assert_frozen_output_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    frz2_q |=> $stable(amp_o));

  assert_no_min_code_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |-> (amp_o != MIN_CODE));
endmodule

bind dds_cos_gen dds_cos_gen_chk #(.ACC_W(ACC_W), .AMP_W(AMP_W)) chk_i (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .upd_i   (upd_i),
  .ftw_i   (ftw_i),
  .amp_o   (amp_o),
  .valid_o (valid_o)
);

// File: tb/dds_cos_gen_tb_top.sv
`timescale 1ns/1ps
module dds_cos_gen_tb_top;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              upd = 1'b0;
  logic [31:0]       ftw = '0;
  logic [13:0]       pow = '0;
  logic signed [9:0] amp;
  logic              valid;

  int n_chk = 0;
  int n_err = 0;

  // reference state built from the requirements
  logic [31:0] acc_m;
  logic [31:0] ftw_m;
  logic [13:0] pow_m;

  always #4 clk = ~clk;

  dds_cos_gen dut_i (
    .clk_i   (clk),
    .rst_i   (rst),
    .upd_i   (upd),
    .ftw_i   (ftw),
    .pow_i   (pow),
    .amp_o   (amp),
    .valid_o (valid)
  );

  function automatic real cos_ref(input logic [13:0] p);
    return 511.0 * $cos(2.0 * 3.14159265358979323846 * real'(p) / 16384.0);
  endfunction

  task automatic chk_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, advance the model, sample at the next negedge
  task automatic cyc(input logic u, input logic [31:0] f, input logic [13:0] p, input string req);
    real exp_a;
    real d;
    logic [13:0] ph;
    upd = u; ftw = f; pow = p;
    ph = acc_m[31:18] + pow_m;
    exp_a = cos_ref(ph);
    acc_m = acc_m + ftw_m;
    if (u) begin
      ftw_m = (f > 32'h8000_0000) ? 32'h8000_0000 : f;
      pow_m = p;
    end
    @(negedge clk);
    n_chk++;
    d = real'(amp) - exp_a;
    if (d < 0.0) d = -d;
    if (valid !== 1'b1 || d > 1.0 || amp == -10'sd512) begin
      n_err++;
      $display("FAIL %s: amp=%0d valid=%0b expected=%f valid=1", req, amp, valid, exp_a);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; upd = 1'b0;
    repeat (3) @(negedge clk);
    chk_int("R1 valid in reset", int'(valid), 0);
    chk_int("R1 amp in reset", int'(amp), 0);
    acc_m = '0; ftw_m = '0; pow_m = '0;
    rst = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int prev;
    do_reset();

    // R2 R7: first samples after reset, zero phase is full positive scale
    for (int i = 0; i < 4; i++) cyc(1'b0, 32'h0, 14'h0, "R2 R7 start");
    chk_int("R7 zero phase", int'(amp), 511);

    // R3 R7 R9: one phase code per clock, full period plus margin
    cyc(1'b1, 32'h0004_0000, 14'h0, "R6 load sweep");
    for (int i = 0; i < 16400; i++) cyc(1'b0, 32'h0, 14'h0, "R3 R7 R9 sweep");

    // R6: inputs move without the strobe and must be ignored
    for (int i = 0; i < 50; i++) cyc(1'b0, 32'h1234_5678 + i, 14'(i * 97), "R6 no strobe");

    // R3: non-power-of-two word, exercises carries into the phase bits
    cyc(1'b1, 32'h0123_4567, 14'h0, "R6 load odd ftw");
    for (int i = 0; i < 600; i++) cyc(1'b0, 32'h0, 14'h0, "R3 odd ftw");

    // R5: offset on, then off; accumulator must not have been disturbed
    cyc(1'b1, 32'h0123_4567, 14'd4096, "R5 offset on");
    for (int i = 0; i < 200; i++) cyc(1'b0, 32'h0, 14'h0, "R5 offset held");
    cyc(1'b1, 32'h0123_4567, 14'd0, "R5 offset off");
    for (int i = 0; i < 200; i++) cyc(1'b0, 32'h0, 14'h0, "R5 offset removed");

    // R8: zero tuning word freezes the output
    cyc(1'b1, 32'h0, 14'd0, "R8 load zero");
    cyc(1'b0, 32'h0, 14'h0, "R8 settle");
    prev = int'(amp);
    for (int i = 0; i < 40; i++) begin
      cyc(1'b0, 32'h0, 14'h0, "R8 frozen");
      chk_int("R8 frozen stable", int'(amp), prev);
    end

    // R5 R6: step the offset over the whole range with the phase frozen
    for (int i = 0; i < 16384; i += 37) begin
      cyc(1'b1, 32'h0, 14'(i), "R5 R6 offset step");
      cyc(1'b0, 32'h0, 14'h0, "R5 offset sample");
    end

    // R4: an oversized word is clamped to half a turn, samples alternate sign
    cyc(1'b1, 32'hFFFF_FFFF, 14'd0, "R4 load big");
    cyc(1'b0, 32'h0, 14'h0, "R4 settle");
    for (int i = 0; i < 20; i++) begin
      prev = int'(amp);
      cyc(1'b0, 32'h0, 14'h0, "R4 clamp");
      chk_int("R4 negated sample", int'(amp), -prev);
    end

    // R1 R2: reset in the middle of a run
    do_reset();
    cyc(1'b0, 32'h0, 14'h0, "R2 after reset");
    chk_int("R1 R7 acc cleared", int'(amp), 511);

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule